// File: doc/BRIEF.md
# E1 CRC-4 Multiframe Synchronizer

This block decides whether a received 2.048 Mbit/s E1 stream carries CRC-4 multiframing and, if so, holds or drops CRC-4 multiframe alignment. It sits behind a basic frame aligner. From that aligner it receives a level that shows basic frame sync, a pulse once per 125 us frame, a flag that marks a frame in which the CRC multiframe alignment word was found, and a strobe for each checked submultiframe with its CRC verdict.

Once basic frame sync is present, the block hunts for two alignment words inside a short window of 64 frames. A longer supervisory window of 3200 frames runs at the same time. A short window that ends without alignment asks the aligner to start a fresh basic frame search. A long window that ends without alignment marks the far end as not sending CRC-4. While aligned, CRC errors are counted over a window of 8000 frames, and too many of them drop alignment. The block also keeps the CRC verdict of the latest first and second submultiframes. That status does not depend on the alignment state.

Top module: `crc4_mf_sync`

## Requirements
- R1: After reset, mf_locked, mf_hunting, reframe_req, crc_interwork, smf1_crc_bad and smf2_crc_bad are all 0.
- R2: While idle, a high bfa_sync raises mf_hunting on the next clock. Both search windows then start from zero frames.
- R3: While hunting, a frame (frame_tick high) with mfa_seen high that follows an earlier such frame in the same short window sets mf_locked and clears mf_hunting on the next clock.
- R4: While hunting, the 64th frame_tick of a short window that has not produced alignment gives a one-cycle reframe_req pulse on the next clock. Any alignment word already seen is discarded, and a new short window begins.
- R5: While hunting, the 3200th frame_tick since the search started raises crc_interwork, unless that same frame completes alignment. crc_interwork stays high until alignment is gained or bfa_sync falls.
- R6: A low bfa_sync clears mf_locked, mf_hunting and crc_interwork on the next clock and returns both search windows to zero.
- R7: While locked, the 915th errored submultiframe (smf_valid and smf_crc_err both high) inside one error window drops mf_locked, raises mf_hunting and pulses reframe_req, all on the next clock.
- R8: The error window is 8000 frame_ticks long. It starts when lock is gained, and its error count restarts at each window boundary, so 914 errors in each of two windows keep the lock.
- R9: A smf_valid strobe with smf_sel=0 loads smf_crc_err into smf1_crc_bad, and one with smf_sel=1 loads it into smf2_crc_bad. The other bit holds, both bits hold without a strobe, and this happens in every alignment state.
- R10: An mfa_seen pulse in a cycle where frame_tick is low does not count toward alignment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_tick | input | 1 | One-cycle pulse per received 125 us frame |
| bfa_sync | input | 1 | Basic frame alignment held by the upstream aligner |
| mfa_seen | input | 1 | CRC multiframe alignment word found in this frame (qualified by frame_tick) |
| smf_valid | input | 1 | Submultiframe CRC check result is present |
| smf_sel | input | 1 | Which submultiframe the result belongs to: 0 first, 1 second |
| smf_crc_err | input | 1 | CRC mismatch for that submultiframe |
| mf_locked | output | 1 | CRC-4 multiframe alignment held |
| mf_hunting | output | 1 | Search for CRC-4 multiframe alignment in progress |
| reframe_req | output | 1 | One-cycle request for a new basic frame search |
| crc_interwork | output | 1 | Far end judged not to send CRC-4 |
| smf1_crc_bad | output | 1 | Latest first submultiframe failed CRC |
| smf2_crc_bad | output | 1 | Latest second submultiframe failed CRC |

## Verification
On every cycle the assertions check where each state change may come from. Lock may only follow a qualified alignment frame during a hunt. An mfa_seen without frame_tick never yields lock. Interworking only rises during a hunt. A dropped basic sync clears lock and interworking, and a lock lost for errors lands in hunting with a reframe pulse. They also bound the window counters and keep the status bits stable when no strobe arrives. Only the bench scenarios can show the exact frame counts: the 64th and 3200th ticks, the 915th error, and the error count restarting at the 8000-tick boundary. They also show that an alignment word seen before a window expiry is discarded.

// File: rtl/crc4s_pkg.sv
package crc4s_pkg;

  typedef enum logic [1:0] {
    SYNC_IDLE = 2'd0,
    SYNC_HUNT = 2'd1,
    SYNC_LOCK = 2'd2
  } mfs_state_t;

  localparam int unsigned N_SMF = 2;

endpackage

// File: rtl/crc4s_frame_timer.sv
module crc4s_frame_timer #(
  parameter int unsigned LIMIT = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic adv,
  output logic expire
);
  localparam int unsigned CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign expire = adv && !clr && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)         cnt_d = '0;
    else if (expire) cnt_d = '0;
    else if (adv)    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R4: window counter never passes its last frame
  a_r4_timer_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

endmodule

// File: rtl/crc4s_err_window.sv
module crc4s_err_window #(
  parameter int unsigned WINDOW = 8000,
  parameter int unsigned LIMIT  = 914
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic adv,
  input  logic err_hit,
  output logic lost
);
  localparam int unsigned EW = $clog2(LIMIT + 2);
  localparam logic [EW-1:0] LIM = EW'(LIMIT);

  logic          win_end;
  logic [EW-1:0] err_q, err_d, base;

  crc4s_frame_timer #(.LIMIT(WINDOW)) u_win (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (!active),
    .adv    (active && adv),
    .expire (win_end)
  );

  always_comb begin
    base  = win_end ? '0 : err_q;
    lost  = active && err_hit && (base == LIM);
    err_d = base;
    if (!active || lost) err_d = '0;
    else if (err_hit)    err_d = base + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= '0;
    else        err_q <= err_d;
  end

  // R8: count within a window never exceeds the tolerated number
  a_r8_err_range: assert property (@(posedge clk) disable iff (!rst_n)
    err_q <= LIM);

endmodule

// File: rtl/crc4s_smf_status.sv
module crc4s_smf_status
  import crc4s_pkg::*;
#(
  parameter int unsigned NS = N_SMF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          upd,
  input  logic [SW-1:0] sel,
  input  logic          bad,
  output logic [NS-1:0] status
);
  localparam int unsigned SW = (NS > 1) ? $clog2(NS) : 1;

  for (genvar i = 0; i < NS; i++) begin : g_smf
    logic st_q, st_d;
    always_comb begin
      st_d = st_q;
      if (upd && (sel == SW'(i))) st_d = bad;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= 1'b0;
      else        st_q <= st_d;
    end
    assign status[i] = st_q;
  end

  // R9: status holds when no result arrives
  a_r9_status_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(status));

endmodule

// File: rtl/crc4_mf_sync.sv
module crc4_mf_sync
  import crc4s_pkg::*;
#(
  parameter int unsigned SHORT_FRAMES = 64,
  parameter int unsigned LONG_FRAMES  = 3200,
  parameter int unsigned SEC_FRAMES   = 8000,
  parameter int unsigned ERR_LIMIT    = 914
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_tick,
  input  logic bfa_sync,
  input  logic mfa_seen,
  input  logic smf_valid,
  input  logic smf_sel,
  input  logic smf_crc_err,
  output logic mf_locked,
  output logic mf_hunting,
  output logic reframe_req,
  output logic crc_interwork,
  output logic smf1_crc_bad,
  output logic smf2_crc_bad
);
  mfs_state_t state_q, state_d;
  logic found_q, found_d;
  logic iw_q, iw_d;
  logic refr_q, refr_d;
  logic in_hunt, in_lock;
  logic short_exp, long_exp, crc_lost;
  logic [N_SMF-1:0] smf_bad;

  assign in_hunt = (state_q == SYNC_HUNT);
  assign in_lock = (state_q == SYNC_LOCK);

  crc4s_frame_timer #(.LIMIT(SHORT_FRAMES)) u_short (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (!in_hunt),
    .adv    (in_hunt && bfa_sync && frame_tick),
    .expire (short_exp)
  );

  crc4s_frame_timer #(.LIMIT(LONG_FRAMES)) u_long (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (!in_hunt),
    .adv    (in_hunt && bfa_sync && frame_tick && !iw_q),
    .expire (long_exp)
  );

  crc4s_err_window #(.WINDOW(SEC_FRAMES), .LIMIT(ERR_LIMIT)) u_errwin (
    .clk     (clk),
    .rst_n   (rst_n),
    .active  (in_lock),
    .adv     (frame_tick),
    .err_hit (smf_valid && smf_crc_err),
    .lost    (crc_lost)
  );

  crc4s_smf_status #(.NS(N_SMF)) u_smf (
    .clk    (clk),
    .rst_n  (rst_n),
    .upd    (smf_valid),
    .sel    (smf_sel),
    .bad    (smf_crc_err),
    .status (smf_bad)
  );

  always_comb begin
    state_d = state_q;
    found_d = found_q;
    iw_d    = iw_q;
    refr_d  = 1'b0;
    unique case (state_q)
      SYNC_IDLE: begin
        iw_d    = 1'b0;
        found_d = 1'b0;
        if (bfa_sync) state_d = SYNC_HUNT;
      end
      SYNC_HUNT: begin
        if (!bfa_sync) begin
          state_d = SYNC_IDLE;
          found_d = 1'b0;
          iw_d    = 1'b0;
        end else if (frame_tick) begin
          if (mfa_seen && found_q) begin
            state_d = SYNC_LOCK;
            found_d = 1'b0;
            iw_d    = 1'b0;
          end else begin
            if (short_exp) begin
              found_d = 1'b0;
              refr_d  = 1'b1;
            end else if (mfa_seen) begin
              found_d = 1'b1;
            end
            if (long_exp) iw_d = 1'b1;
          end
        end
      end
      SYNC_LOCK: begin
        if (!bfa_sync) begin
          state_d = SYNC_IDLE;
        end else if (crc_lost) begin
          state_d = SYNC_HUNT;
          refr_d  = 1'b1;
        end
      end
      default: state_d = SYNC_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SYNC_IDLE;
      found_q <= 1'b0;
      iw_q    <= 1'b0;
      refr_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      found_q <= found_d;
      iw_q    <= iw_d;
      refr_q  <= refr_d;
    end
  end

  assign mf_locked     = in_lock;
  assign mf_hunting    = in_hunt;
  assign reframe_req   = refr_q;
  assign crc_interwork = iw_q;
  assign smf1_crc_bad  = smf_bad[0];
  assign smf2_crc_bad  = smf_bad[1];

  // R3: lock only follows a qualified alignment frame during a hunt
  a_r3_lock_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mf_locked) |-> $past(mf_hunting && frame_tick && mfa_seen));

  // R4: reframe request is a single-cycle pulse
  a_r4_reframe_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    reframe_req |=> !reframe_req);

  // R5: interworking only rises out of a hunt
  a_r5_iw_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(crc_interwork) |-> $past(mf_hunting));

  // R6: dropped basic sync clears lock and interworking
  a_r6_bfa_drop: assert property (@(posedge clk) disable iff (!rst_n)
    !bfa_sync |=> (!mf_locked && !crc_interwork));

  // R7: lock lost under held basic sync goes back to hunting with reframe
  a_r7_loss_path: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(mf_locked) && $past(bfa_sync)) |-> (mf_hunting && reframe_req));

  // R10: no lock without a frame tick
  a_r10_tick_qual: assert property (@(posedge clk) disable iff (!rst_n)
    (mf_hunting && !frame_tick) |=> !mf_locked);

endmodule

// File: tb/crc4_mf_sync_bench.sv
module crc4_mf_sync_bench;
  logic clk = 1'b0;
  logic rst_n;
  logic frame_tick, bfa_sync, mfa_seen, smf_valid, smf_sel, smf_crc_err;
  logic mf_locked, mf_hunting, reframe_req, crc_interwork, smf1_crc_bad, smf2_crc_bad;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  crc4_mf_sync u_crc4_mf_sync (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .bfa_sync(bfa_sync),
    .mfa_seen(mfa_seen), .smf_valid(smf_valid), .smf_sel(smf_sel),
    .smf_crc_err(smf_crc_err), .mf_locked(mf_locked), .mf_hunting(mf_hunting),
    .reframe_req(reframe_req), .crc_interwork(crc_interwork),
    .smf1_crc_bad(smf1_crc_bad), .smf2_crc_bad(smf2_crc_bad)
  );

  // {valid, sel, err, expected first, expected second}
  localparam logic [4:0] SMF_VEC [8] = '{
    5'b10110, 5'b11111, 5'b00011, 5'b10001,
    5'b01001, 5'b11000, 5'b11101, 5'b10111
  };

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic ticks(input int n, input logic mfa);
    frame_tick = 1'b1;
    mfa_seen   = mfa;
    for (int i = 0; i < n; i++) step();
    frame_tick = 1'b0;
    mfa_seen   = 1'b0;
  endtask

  task automatic errs(input int n);
    smf_valid = 1'b1; smf_crc_err = 1'b1; smf_sel = 1'b0;
    for (int i = 0; i < n; i++) step();
    smf_valid = 1'b0; smf_crc_err = 1'b0;
  endtask

  initial begin
    #800000;
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    frame_tick = 0; bfa_sync = 0; mfa_seen = 0;
    smf_valid = 0; smf_sel = 0; smf_crc_err = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    step();
    chk("R1 locked", mf_locked, 1'b0);
    chk("R1 hunting", mf_hunting, 1'b0);
    chk("R1 reframe", reframe_req, 1'b0);
    chk("R1 interwork", crc_interwork, 1'b0);
    chk("R1 smf1", smf1_crc_bad, 1'b0);
    chk("R1 smf2", smf2_crc_bad, 1'b0);

    // R9: status table, run while idle
    for (int v = 0; v < 8; v++) begin
      smf_valid = SMF_VEC[v][4]; smf_sel = SMF_VEC[v][3]; smf_crc_err = SMF_VEC[v][2];
      step();
      chk("R9 smf1", smf1_crc_bad, SMF_VEC[v][1]);
      chk("R9 smf2", smf2_crc_bad, SMF_VEC[v][0]);
    end
    smf_valid = 0; smf_sel = 0; smf_crc_err = 0;

    // R2
    bfa_sync = 1'b1;
    step();
    chk("R2 hunting", mf_hunting, 1'b1);
    ticks(1, 1'b1);
    ticks(2, 1'b0);
    chk("R3 one word", mf_locked, 1'b0);
    mfa_seen = 1'b1; step(); mfa_seen = 1'b0;
    chk("R10 untimed word", mf_locked, 1'b0);
    ticks(1, 1'b1);
    chk("R3 locked", mf_locked, 1'b1);
    chk("R3 hunting", mf_hunting, 1'b0);

    // R8: 914 errors in window one, boundary, 914 in window two
    errs(914);
    chk("R8 first window", mf_locked, 1'b1);
    ticks(8000, 1'b0);
    errs(914);
    chk("R8 second window", mf_locked, 1'b1);
    errs(1);
    chk("R7 locked", mf_locked, 1'b0);
    chk("R7 hunting", mf_hunting, 1'b1);
    chk("R7 reframe", reframe_req, 1'b1);
    step();
    chk("R4 pulse width", reframe_req, 1'b0);

    // R4: short window expiry
    ticks(1, 1'b1);
    ticks(62, 1'b0);
    chk("R4 before expiry", reframe_req, 1'b0);
    ticks(1, 1'b0);
    chk("R4 reframe", reframe_req, 1'b1);
    ticks(1, 1'b1);
    chk("R4 word discarded", mf_locked, 1'b0);
    ticks(1, 1'b1);
    chk("R4 relock", mf_locked, 1'b1);

    // R6
    bfa_sync = 1'b0; step();
    chk("R6 locked", mf_locked, 1'b0);
    chk("R6 hunting", mf_hunting, 1'b0);

    // R5
    bfa_sync = 1'b1; step();
    ticks(3199, 1'b0);
    chk("R5 before long expiry", crc_interwork, 1'b0);
    ticks(1, 1'b0);
    chk("R5 interwork", crc_interwork, 1'b1);
    ticks(5, 1'b0);
    chk("R5 held", crc_interwork, 1'b1);
    ticks(2, 1'b1);
    chk("R5 cleared by lock", crc_interwork, 1'b0);
    chk("R5 locked", mf_locked, 1'b1);

    bfa_sync = 1'b0; step();
    bfa_sync = 1'b1; step();
    ticks(3200, 1'b0);
    chk("R5 interwork again", crc_interwork, 1'b1);
    bfa_sync = 1'b0; step();
    chk("R6 interwork", crc_interwork, 1'b0);
    chk("R6 hunting off", mf_hunting, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule